// File: doc/BRIEF.md
# Reference-Timed Clock Output Enable Sequencer

This block takes a clock that another circuit has already produced and passes it to two identical output pins under the control of an active-low enable. The enable comes from outside and has no fixed timing relation to either clock. The enable pin is pulled high when nothing drives it, which keeps the outputs off.

When the enable goes low, the block does not release the clock at once. It first counts a set number of rising edges on a slow reference pulse, which gives the upstream clock time to settle. The count is 400 edges when the fast reference rate is selected and 200 edges when the slow rate is selected. Either way the wait is about the same length of time. After the count, the outputs start on a whole clock cycle.

When the enable goes high again, the clock cycle already on the outputs runs to its end. Both outputs then stay low. A status flag shows whether the outputs are passing the clock. The reference must already be toggling before the enable is asserted.

Top module: `clk_enable_seq`

## Requirements
- R1: While `en_n` is high, both outputs are low. Once `en_n` has been high for four full generated-clock cycles, neither output shows any high phase.
- R2: `clk_out_a` and `clk_out_b` carry the same waveform at all times.
- R3: With `rate_sel` = 1 (fast reference), the first output rising edge comes after exactly `DLY_FAST` (default 400) reference rising edges, counted from the assertion of `en_n`.
- R4: With `rate_sel` = 0 (slow reference), the first output rising edge comes after exactly `DLY_SLOW` (default 200) reference rising edges.
- R5: Every output high phase lasts a full half period of the generated clock, so no pulse is ever shortened. If `en_n` rises during a high phase, that pulse runs to its end, and exactly three more full pulses follow before the outputs stay low. These three pulses come from the two-flop synchronizer and the one-cycle counter clear.
- R6: If `en_n` is deasserted before the outputs start, the edge count restarts from zero. A later assertion then needs the full count again. The aborted attempt produces no output pulse.
- R7: `running` is high exactly when the outputs pass the clock. During each generated-clock high phase, `clk_out_a` equals `running`.
- R8: While `rst_n` is low at a clock edge, the block returns to its idle state: outputs low, `running` low, edge count cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_gen | input | 1 | Generated clock to be gated; it also clocks the block |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference pulse, asynchronous; its rising edges are counted |
| rate_sel | input | 1 | Reference rate select: 1 = fast rate (DLY_FAST edges), 0 = slow rate (DLY_SLOW edges); held static while enabled |
| en_n | input | 1 | Asynchronous active-low output enable |
| clk_out_a | output | 1 | Gated clock copy A |
| clk_out_b | output | 1 | Gated clock copy B |
| running | output | 1 | High while the outputs pass the clock |

## Verification
The assertions run on every cycle and check the following:
- the edge counter never exceeds the larger delay target;
- the counter clears whenever the synchronized enable is low;
- the release flag only rises on a counted reference edge;
- the gate opens and closes only in line with its request;
- the gate is shut two cycles after the synchronized enable drops.

Only the bench scenarios can show the rest. These are the exact number of reference edges before the first output edge in each rate mode, and the restart after an aborted enable. They also include the exact count of trailing pulses after a disable, and that no output pulse is ever cut short.

// File: rtl/cgs_pkg.sv
// Package: shared types and helpers for the clock enable sequencer.
// Assumes: rate select is a single bit, 1 meaning the fast reference.
package cgs_pkg;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    // Larger of two delay targets, used to size the edge counter.
    function automatic int unsigned max_target(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cgs_sync.sv
// Module: multi-stage bit synchronizer.
// Brings an asynchronous level into the clk domain through STAGES flops.
// Assumes: the input is a level that stays put for at least one clk period.
module cgs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= {STAGES{RST_VAL}};
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/cgs_delay_cnt.sv
// Module: settle-delay counter.
// Counts rising edges of the synchronized reference while the enable request
// is active. It raises open_req once the count reaches the target chosen by
// rate_sel. The count clears whenever the request drops.
// Assumes: ref_s is already synchronized and rate_sel is static while enabled.
module cgs_delay_cnt
    import cgs_pkg::*;
#(
    parameter int unsigned DLY_FAST = 400,
    parameter int unsigned DLY_SLOW = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic ref_s,
    input  logic rate_sel,
    output logic open_req
);
    localparam int unsigned CNT_MAX = max_target(DLY_FAST, DLY_SLOW);
    localparam int          CNT_W   = $clog2(CNT_MAX + 1);

    logic             ref_d;
    logic             ref_rise;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] target;

    // Delay the synchronized reference by one flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_d <= 1'b0;
        else        ref_d <= ref_s;
    end

    assign ref_rise = ref_s & ~ref_d;
    assign cnt_inc  = cnt + CNT_W'(1);

    // Pick the edge target for the selected reference rate.
    always_comb begin
        if (rate_e'(rate_sel) == RATE_FAST) target = CNT_W'(DLY_FAST);
        else                                target = CNT_W'(DLY_SLOW);
    end

    // Count reference edges while requested; clear when the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_req) begin
            cnt      <= '0;
            open_req <= 1'b0;
        end else if (ref_rise && !open_req) begin
            cnt <= cnt_inc;
            if (cnt_inc >= target) open_req <= 1'b1;
        end
    end

    // R3/R4: the counter never runs beyond the larger target.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(CNT_MAX));

    // R6: a dropped request always leaves the count at zero.
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_req |=> (cnt == '0 && !open_req));

    // R4: release only happens on a counted reference edge.
    assert_release_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_req) |-> $past(ref_rise));
endmodule

// File: rtl/cgs_gate.sv
// Module: glitch-free clock gate with NUM_OUT identical copies.
// The gate flop updates on the falling edge, so it changes only while the
// clock is low. A high phase that has started always runs to its end.
// Assumes: clk_in has a duty cycle near 50%; open_req comes from clk_in posedge logic.
module cgs_gate #(
    parameter int NUM_OUT = 2
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic               open_req,
    output logic               gate_on,
    output logic [NUM_OUT-1:0] clk_out
);
    logic gate_q;

    // Latch the open request during the low phase of the clock.
    always_ff @(negedge clk_in) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= open_req;
    end

    assign gate_on = gate_q;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_copy
        assign clk_out[i] = clk_in & gate_q;
    end

    // R5: the gate only opens while open_req is held.
    assert_open_follows_req_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(gate_q) |-> open_req);

    // R5: the gate only closes once the request is gone.
    assert_close_follows_req_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        $fell(gate_q) |-> !open_req);
endmodule

// File: rtl/clk_enable_seq.sv
// Module: clock output enable sequencer (top).
// Synchronizes the enable and the reference into the generated-clock domain,
// waits for the settle count, then gates the clock onto two outputs.
// Assumes: the reference toggles before en_n falls; rate_sel is static while enabled.
module clk_enable_seq #(
    parameter int unsigned DLY_FAST    = 400,
    parameter int unsigned DLY_SLOW    = 200,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk_gen,
    input  logic rst_n,
    input  logic ref_in,
    input  logic rate_sel,
    input  logic en_n,
    output logic clk_out_a,
    output logic clk_out_b,
    output logic running
);
    localparam int NUM_OUT = 2;

    logic               en_n_s;
    logic               en_req;
    logic               ref_s;
    logic               open_req;
    logic [NUM_OUT-1:0] clk_copies;

    cgs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en_sync (
        .clk (clk_gen),
        .rst_n (rst_n),
        .d (en_n),
        .q (en_n_s)
    );

    cgs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_sync (
        .clk (clk_gen),
        .rst_n (rst_n),
        .d (ref_in),
        .q (ref_s)
    );

    assign en_req = ~en_n_s;

    cgs_delay_cnt #(.DLY_FAST(DLY_FAST), .DLY_SLOW(DLY_SLOW)) u_delay (
        .clk (clk_gen),
        .rst_n (rst_n),
        .en_req (en_req),
        .ref_s (ref_s),
        .rate_sel (rate_sel),
        .open_req (open_req)
    );

    cgs_gate #(.NUM_OUT(NUM_OUT)) u_gate (
        .clk_in (clk_gen),
        .rst_n (rst_n),
        .open_req (open_req),
        .gate_on (running),
        .clk_out (clk_copies)
    );

    assign clk_out_a = clk_copies[0];
    assign clk_out_b = clk_copies[1];

    // R1: two sampled cycles of dropped enable leave the outputs shut.
    assert_off_when_disabled_R1: assert property (@(posedge clk_gen) disable iff (!rst_n)
        (!en_req && $past(!en_req)) |-> !running);
endmodule

// File: tb/test_clk_enable_seq.sv
module test_clk_enable_seq;
    localparam int DLY_FAST = 400;
    localparam int DLY_SLOW = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic rate_sel = 1'b1;
    logic en_n = 1'b1;
    logic clk_out_a, clk_out_b, running;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;

    typedef struct {
        int    kind;   // 0: start edge count, 1: pulses after disable
        int    val;
        string req;
    } exp_t;
    exp_t sb_q[$];

    clk_enable_seq #(.DLY_FAST(DLY_FAST), .DLY_SLOW(DLY_SLOW)) i_clk_enable_seq (
        .clk_gen (clk),
        .rst_n (rst_n),
        .ref_in (ref_in),
        .rate_sel (rate_sel),
        .en_n (en_n),
        .clk_out_a (clk_out_a),
        .clk_out_b (clk_out_b),
        .running (running)
    );

    always #10 clk = ~clk;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference generator: 20-cycle period, 4 cycles high.
    initial begin
        forever begin
            repeat (16) @(posedge clk);
            #2 ref_in = 1'b1;
            repeat (4) @(posedge clk);
            #2 ref_in = 1'b0;
        end
    end

    // Monitor: reference edges since enable, and first output edge.
    int  ref_rises = 0;
    bit  armed = 1'b0;
    bit  stopping = 1'b0;
    int  pulses = 0;
    realtime rise_t = 0;

    always @(negedge en_n) if (live) begin ref_rises = 0; armed = 1'b1; end
    always @(posedge ref_in) ref_rises++;

    task automatic pop_cmp(int kind, int act);
        exp_t e;
        if (sb_q.size() == 0) begin
            check(1'b0, "R5", "unexpected event", kind, -1);
        end else begin
            e = sb_q.pop_front();
            check(e.kind == kind, e.req, "event kind", kind, e.kind);
            check(act == e.val, e.req, "measured count", act, e.val);
        end
    endtask

    always @(posedge clk_out_a) begin
        rise_t = $realtime;
        if (stopping) pulses++;
        if (armed) begin
            armed = 1'b0;
            pop_cmp(0, ref_rises);
        end
    end

    // R5: every high phase lasts a full half period (10 ns).
    always @(negedge clk_out_a) if (live)
        check(($realtime - rise_t) == 10.0, "R5", "pulse width ns",
              int'($realtime - rise_t), 10);

    // Count pulses after a disable, then compare.
    always @(posedge en_n) if (live) begin
        pulses = 0;
        stopping = 1'b1;
        repeat (20) @(posedge clk);
        stopping = 1'b0;
        pop_cmp(1, pulses);
    end

    // Per-cycle sampler in the high phase: R1, R2, R7.
    int hi_cnt = 0;
    always @(posedge clk) begin
        #5;
        if (live) begin
            hi_cnt = en_n ? hi_cnt + 1 : 0;
            check(clk_out_a == clk_out_b, "R2", "copy match", clk_out_b, clk_out_a);
            check(clk_out_a == running, "R7", "out vs running", clk_out_a, running);
            if (hi_cnt >= 5)
                check(!clk_out_a && !running, "R1", "disabled output", clk_out_a, 0);
        end
    end

    task automatic enable_on(bit sel, int exp, string req);
        rate_sel = sel;
        @(negedge ref_in);
        #1;
        sb_q.push_back('{0, exp, req});
        en_n = 1'b0;
    endtask

    task automatic enable_off(int exp, string req);
        @(posedge clk);
        #2;
        sb_q.push_back('{1, exp, req});
        en_n = 1'b1;
        repeat (25) @(posedge clk);
    endtask

    task automatic wait_running();
        while (!running) @(posedge clk);
        repeat (40) @(posedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 0, 1);
        finish_run();
    end

    // Driver.
    initial begin
        repeat (5) @(posedge clk);
        #5;
        // R8: reset state.
        check(!clk_out_a && !clk_out_b, "R8", "outputs in reset", clk_out_a, 0);
        check(!running, "R8", "running in reset", running, 0);
        @(posedge clk);
        #2 rst_n = 1'b1;
        live = 1'b1;
        repeat (100) @(posedge clk);   // R1: idle with reference toggling

        enable_on(1'b1, DLY_FAST, "R3");
        wait_running();
        enable_off(3, "R5");

        enable_on(1'b0, DLY_SLOW, "R4");
        wait_running();
        enable_off(3, "R5");

        // R6: abort mid-count, then a full count is needed again.
        enable_on(1'b1, DLY_FAST, "R6");
        repeat (100 * 20) @(posedge clk);
        check(!running, "R6", "not yet running", running, 0);
        sb_q.pop_front();                 // aborted start never occurs
        armed = 1'b0;
        enable_off(0, "R6");
        enable_on(1'b1, DLY_FAST, "R6");
        wait_running();
        enable_off(3, "R5");

        repeat (30) @(posedge clk);
        check(sb_q.size() == 0, "R6", "pending expectations", sb_q.size(), 0);
        finish_run();
    end
endmodule